// File: doc/BRIEF.md
# Privileged Control Register Access Router

This block owns one 64-bit feature access control register and decides, for every read or write request that names it, where the access goes. Each request carries the current exception level (0 to 3) and chooses one of two encodings: the direct name of the register or its EL12 alias, which a hypervisor running in host mode uses to reach the guest copy. The answer is exactly one of six outcomes. The access can hit the register itself. It can be sent to the hypervisor's own trap-control register. It can be sent to a memory slot at offset 0x100, which is used for nested virtualization. It can raise a trap to EL2 or to EL3. Or it can be reported as undefined.

The decision uses several inputs. Two are the register-access trap bits from the EL2 and EL3 trap controls. Two more are separate fine-grained read and write trap bits, together with the EL3-side enable for fine-grained traps. The rest are a 3-bit nested-virtualization field and a host-mode flag. The decision is combinational and is valid in the same cycle as the request. A write that reaches the register is stored on the next rising clock edge. Only the implemented control fields are kept, and every other bit reads as zero. The memory slot and the hypervisor register are outside the block, and the block only signals that an access is redirected to them.

Top module: `ctl_access_router`

## Requirements
- R1: Any request at exception level 0 (`req_el` = 0), with either encoding, gives `out_undef`.
- R2: A direct-name request at EL1 traps to EL2 (`out_trap`=1, `trap_to_el3`=0) when `el2_acc_trap` is set. Otherwise it traps to EL2 when the fine-grained bit for its direction is set (`fg_rd_trap` for reads, `fg_wr_trap` for writes) and fine-grained traps are live. Live means implemented, and either EL3 is absent or `fg_el3_enable` is 1.
- R3: A direct-name request at EL1 that passes the R2 checks traps to EL3 (`trap_to_el3`=1) when `el3_acc_trap` is set. Failing that, it goes to memory (`out_mem`) when `nv_mode` = 3'b111. In every other case it reaches the register (`out_reg`).
- R4: A direct-name request at EL2 traps to EL3 when `el3_acc_trap` is set. Otherwise it goes to the hypervisor register (`out_hyp`) when `in_host` is 1, and reaches the register when `in_host` is 0.
- R5: A direct-name request at EL3 always reaches the register, whatever the trap and mode inputs are.
- R6: An alias request (`req_alias`=1) at EL1 goes to memory when `nv_mode` = 3'b101. Otherwise it traps to EL2 when `nv_mode[0]` is 1, and is undefined in every other case.
- R7: An alias request at EL2 or EL3 is undefined when `in_host` is 0. At EL2 in host mode it traps to EL3 when `el3_acc_trap` is set, and otherwise reaches the register. At EL3 in host mode it always reaches the register.
- R8: `trap_class` is 6'h18 whenever `out_trap` is 1, and 0 otherwise.
- R9: While `req_valid` is 1, exactly one of `out_reg`, `out_hyp`, `out_mem`, `out_trap`, `out_undef` is 1. While `req_valid` is 0, none of them is.
- R10: A write that reaches the register stores `req_wdata` AND 64'h0000_0000_3333_0000 on the next rising edge. The kept bits are 29, 28, 25:24, 21:20 and 17:16, and all other bits read back as zero.
- R11: After reset the register holds zero.
- R12: A write whose outcome is anything other than reaching the register leaves the register unchanged.
- R13: `rd_data` shows the register contents during a read that reaches the register, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alias | input | 1 | 0 = direct name, 1 = EL12 alias |
| req_el | input | 2 | Current exception level 0..3 |
| req_wdata | input | 64 | Write data |
| el2_acc_trap | input | 1 | EL2 register-access trap control |
| el3_acc_trap | input | 1 | EL3 register-access trap control |
| fg_rd_trap | input | 1 | Fine-grained read trap bit |
| fg_wr_trap | input | 1 | Fine-grained write trap bit |
| fg_el3_enable | input | 1 | EL3 enable for fine-grained traps |
| nv_mode | input | 3 | Nested-virtualization field |
| in_host | input | 1 | Hypervisor runs in host mode |
| out_reg | output | 1 | Access reaches the register |
| out_hyp | output | 1 | Access goes to hypervisor trap-control register |
| out_mem | output | 1 | Access goes to memory slot 0x100 |
| out_trap | output | 1 | Access traps |
| trap_to_el3 | output | 1 | Trap target: 1 = EL3, 0 = EL2 |
| trap_class | output | 6 | Trap class code |
| mem_offset | output | 12 | Memory slot offset, 0x100 while out_mem |
| out_undef | output | 1 | Access is undefined |
| rd_data | output | 64 | Read data |

## Verification
All outcome outputs, the trap class and the read data come from combinational logic. They are due in the same cycle as the request. The bench applies each request just after a falling edge and samples 1 ns later, before the next rising edge. A write lands on the following rising edge. The bench confirms it with a read request in the next cycle, using EL3 and the direct name, so the stored value is checked one cycle after the write and the check never depends on the order of events at the edge.

// File: rtl/ctl_router_pkg.sv
package ctl_router_pkg;

    localparam int DATA_W  = 64;
    localparam int EL_W    = 2;
    localparam int NV_W    = 3;
    localparam int CLASS_W = 6;
    localparam int OFS_W   = 12;

    localparam logic [DATA_W-1:0]  KEEP_MASK   = 64'h0000_0000_3333_0000;
    localparam logic [CLASS_W-1:0] ACC_CLASS   = 6'h18;
    localparam logic [OFS_W-1:0]   SLOT_OFFSET = 12'h100;
    localparam logic [NV_W-1:0]    NV_DIRECT   = 3'b111;
    localparam logic [NV_W-1:0]    NV_ALIAS    = 3'b101;

    typedef enum logic [2:0] {
        RT_NONE  = 3'd0,
        RT_REG   = 3'd1,
        RT_HYP   = 3'd2,
        RT_MEM   = 3'd3,
        RT_TRAP2 = 3'd4,
        RT_TRAP3 = 3'd5,
        RT_UNDEF = 3'd6
    } route_e;

    typedef struct packed {
        logic            write;
        logic            alias_sel;
        logic [EL_W-1:0] el;
    } req_t;

    typedef struct packed {
        logic            el2_trap;
        logic            el3_trap;
        logic            fg_rd;
        logic            fg_wr;
        logic            fg_en;
        logic [NV_W-1:0] nv;
        logic            host;
    } ctl_t;

    function automatic logic [DATA_W-1:0] keep_bits(input logic [DATA_W-1:0] v);
        return v & KEEP_MASK;
    endfunction

endpackage

// File: rtl/route_decode.sv
module route_decode
    import ctl_router_pkg::*;
#(
    parameter bit HAS_EL3 = 1'b1,
    parameter bit HAS_FGT = 1'b1
) (
    input  logic   valid,
    input  req_t   req,
    input  ctl_t   ctl,
    output route_e route
);
    logic fg_live, fg_hit, el3_hit;

    always_comb begin
        fg_live = HAS_FGT && (!HAS_EL3 || ctl.fg_en);
        fg_hit  = fg_live && (req.write ? ctl.fg_wr : ctl.fg_rd);
        el3_hit = HAS_EL3 && ctl.el3_trap;
    end

    always_comb begin
        route = RT_NONE;
        if (valid) begin
            unique case (req.el)
                2'd0: route = RT_UNDEF;
                2'd1: begin
                    if (req.alias_sel) begin
                        if (ctl.nv == NV_ALIAS)    route = RT_MEM;
                        else if (ctl.nv[0])        route = RT_TRAP2;
                        else                       route = RT_UNDEF;
                    end else begin
                        if (ctl.el2_trap)          route = RT_TRAP2;
                        else if (fg_hit)           route = RT_TRAP2;
                        else if (el3_hit)          route = RT_TRAP3;
                        else if (ctl.nv == NV_DIRECT) route = RT_MEM;
                        else                       route = RT_REG;
                    end
                end
                2'd2: begin
                    if (req.alias_sel) begin
                        if (!ctl.host)             route = RT_UNDEF;
                        else if (el3_hit)          route = RT_TRAP3;
                        else                       route = RT_REG;
                    end else begin
                        if (el3_hit)               route = RT_TRAP3;
                        else if (ctl.host)         route = RT_HYP;
                        else                       route = RT_REG;
                    end
                end
                default: begin
                    if (req.alias_sel && !ctl.host) route = RT_UNDEF;
                    else                            route = RT_REG;
                end
            endcase
        end
    end
endmodule

// File: rtl/ctl_reg_store.sv
module ctl_reg_store
    import ctl_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= keep_bits(wdata);
    end

    // R10
    store_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> (q == ($past(wdata) & KEEP_MASK)));

    // R12
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(q));
endmodule

// File: rtl/ctl_access_router.sv
module ctl_access_router
    import ctl_router_pkg::*;
#(
    parameter bit HAS_EL3 = 1'b1,
    parameter bit HAS_FGT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_alias,
    input  logic [EL_W-1:0]    req_el,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               el2_acc_trap,
    input  logic               el3_acc_trap,
    input  logic               fg_rd_trap,
    input  logic               fg_wr_trap,
    input  logic               fg_el3_enable,
    input  logic [NV_W-1:0]    nv_mode,
    input  logic               in_host,
    output logic               out_reg,
    output logic               out_hyp,
    output logic               out_mem,
    output logic               out_trap,
    output logic               trap_to_el3,
    output logic [CLASS_W-1:0] trap_class,
    output logic [OFS_W-1:0]   mem_offset,
    output logic               out_undef,
    output logic [DATA_W-1:0]  rd_data
);
    req_t              req;
    ctl_t              ctl;
    route_e            route;
    logic [DATA_W-1:0] reg_q;
    logic              wr_en;

    assign req = '{write: req_write, alias_sel: req_alias, el: req_el};
    assign ctl = '{el2_trap: el2_acc_trap, el3_trap: el3_acc_trap,
                   fg_rd: fg_rd_trap, fg_wr: fg_wr_trap, fg_en: fg_el3_enable,
                   nv: nv_mode, host: in_host};

    route_decode #(.HAS_EL3(HAS_EL3), .HAS_FGT(HAS_FGT)) u_decode (
        .valid (req_valid),
        .req   (req),
        .ctl   (ctl),
        .route (route)
    );

    assign wr_en = (route == RT_REG) && req_write;

    ctl_reg_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wdata (req_wdata),
        .q     (reg_q)
    );

    always_comb begin
        out_reg     = (route == RT_REG);
        out_hyp     = (route == RT_HYP);
        out_mem     = (route == RT_MEM);
        out_trap    = (route == RT_TRAP2) || (route == RT_TRAP3);
        trap_to_el3 = (route == RT_TRAP3);
        out_undef   = (route == RT_UNDEF);
        trap_class  = out_trap ? ACC_CLASS : '0;
        mem_offset  = out_mem ? SLOT_OFFSET : '0;
        rd_data     = (out_reg && !req_write) ? reg_q : '0;
    end

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones({out_reg, out_hyp, out_mem, out_trap, out_undef}) == 1));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(out_reg || out_hyp || out_mem || out_trap || out_undef));

    // R1
    el0_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_el == 2'd0) |-> out_undef);

    // R8
    trap_class_chk: assert property (@(posedge clk) disable iff (rst)
        out_trap |-> (trap_class == 6'h18));

    // R5
    el3_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_el == 2'd3 && !req_alias) |-> out_reg);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_reg && !req_write) |-> ((rd_data & ~KEEP_MASK) == '0));
endmodule

// File: tb/test_ctl_access_router.sv
module test_ctl_access_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_alias = 1'b0;
    logic [1:0]  req_el = 2'd0;
    logic [63:0] req_wdata = '0;
    logic        el2_acc_trap = 1'b0, el3_acc_trap = 1'b0;
    logic        fg_rd_trap = 1'b0, fg_wr_trap = 1'b0, fg_el3_enable = 1'b0;
    logic [2:0]  nv_mode = 3'd0;
    logic        in_host = 1'b0;
    logic        out_reg, out_hyp, out_mem, out_trap, trap_to_el3, out_undef;
    logic [5:0]  trap_class;
    logic [11:0] mem_offset;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ctl_access_router i_ctl_access_router (.*);

    // vector: [15]write [14]alias [13:12]el [11]el2t [10]el3t [9]fgr [8]fgw
    //         [7]fge [6:4]nv [3]host [2:0]expected (1 reg,2 hyp,3 mem,4 trap EL2,5 trap EL3,6 undef)
    localparam int NV = 23;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,3'd6},
        {1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b101,1'b1,3'd6},
        {1'b0,1'b0,2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,3'b111,1'b0,3'd4},
        {1'b0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b1,3'b000,1'b0,3'd4},
        {1'b0,1'b0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,3'b000,1'b0,3'd1},
        {1'b1,1'b0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b1,3'b000,1'b0,3'd1},
        {1'b1,1'b0,2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,3'b000,1'b0,3'd4},
        {1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,3'b111,1'b0,3'd5},
        {1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b111,1'b0,3'd3},
        {1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b101,1'b0,3'd1},
        {1'b0,1'b0,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,1'b1,3'd5},
        {1'b0,1'b0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,3'd2},
        {1'b0,1'b0,2'd2,1'b1,1'b0,1'b1,1'b0,1'b1,3'b111,1'b0,3'd1},
        {1'b0,1'b0,2'd3,1'b1,1'b1,1'b1,1'b1,1'b1,3'b111,1'b1,3'd1},
        {1'b0,1'b1,2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,3'b101,1'b0,3'd3},
        {1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b111,1'b0,3'd4},
        {1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b001,1'b0,3'd4},
        {1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b110,1'b1,3'd6},
        {1'b0,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,3'd6},
        {1'b0,1'b1,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,1'b1,3'd5},
        {1'b0,1'b1,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,3'd1},
        {1'b0,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,3'd6},
        {1'b0,1'b1,2'd3,1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,1'b1,3'd1}
    };

    function automatic string tag_of(int i);
        if (i < 2)  return "R1";
        if (i < 4)  return "R2";
        if (i < 5)  return "R2";
        if (i < 7)  return "R2";
        if (i < 10) return "R3";
        if (i < 13) return "R4";
        if (i < 14) return "R5";
        if (i < 18) return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] seen_code();
        if (out_reg)   return 3'd1;
        if (out_hyp)   return 3'd2;
        if (out_mem)   return 3'd3;
        if (out_trap)  return trap_to_el3 ? 3'd5 : 3'd4;
        if (out_undef) return 3'd6;
        return 3'd0;
    endfunction

    task automatic quiet_ctl();
        el2_acc_trap = 0; el3_acc_trap = 0; fg_rd_trap = 0; fg_wr_trap = 0;
        fg_el3_enable = 0; nv_mode = 3'd0; in_host = 0;
    endtask

    task automatic read_reg(input string tag, input logic [63:0] exp);
        @(negedge clk);
        quiet_ctl();
        req_valid = 1; req_write = 0; req_alias = 0; req_el = 2'd3;
        #1;
        check(tag, "register readback", rd_data, exp);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic write_req(input logic [1:0] el, input logic alias_sel,
                             input logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_alias = alias_sel; req_el = el;
        req_wdata = d;
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R11: reset state
        read_reg("R11", 64'h0);

        // R9: idle produces no outcome
        @(negedge clk);
        req_valid = 0; #1;
        check("R9", "idle outcome", {61'd0, seen_code()}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1;
            req_write = VEC[i][15]; req_alias = VEC[i][14]; req_el = VEC[i][13:12];
            el2_acc_trap = VEC[i][11]; el3_acc_trap = VEC[i][10];
            fg_rd_trap = VEC[i][9]; fg_wr_trap = VEC[i][8]; fg_el3_enable = VEC[i][7];
            nv_mode = VEC[i][6:4]; in_host = VEC[i][3]; req_wdata = '0;
            #1;
            check(tag_of(i), "outcome", {61'd0, seen_code()}, {61'd0, VEC[i][2:0]});
            check("R8", "trap class", {58'd0, trap_class},
                  (VEC[i][2:0] == 3'd4 || VEC[i][2:0] == 3'd5) ? 64'h18 : 64'h0);
            check("R9", "outcome count",
                  64'(out_reg + out_hyp + out_mem + out_trap + out_undef), 64'd1);
            if (VEC[i][2:0] == 3'd3)
                check("R3", "memory slot offset", {52'd0, mem_offset}, 64'h100);
        end
        @(negedge clk);
        req_valid = 0;

        // R10: masked write at EL3 direct
        quiet_ctl();
        write_req(2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        read_reg("R10", 64'h0000_0000_3333_0000);

        // R12: trapped write leaves the register alone
        el2_acc_trap = 1;
        write_req(2'd1, 1'b0, 64'h0);
        #1;
        check("R12", "trapped write outcome", {61'd0, seen_code()}, 64'd4);
        read_reg("R12", 64'h0000_0000_3333_0000);

        // R12: write redirected to hypervisor register
        in_host = 1;
        write_req(2'd2, 1'b0, 64'h0);
        read_reg("R12", 64'h0000_0000_3333_0000);

        // R12: write redirected to memory
        nv_mode = 3'b111;
        write_req(2'd1, 1'b0, 64'h0);
        read_reg("R12", 64'h0000_0000_3333_0000);

        // R7: alias write at EL2 in host mode reaches the register
        in_host = 1;
        write_req(2'd2, 1'b1, 64'h0000_0000_1020_0000);
        read_reg("R7", 64'h0000_0000_1020_0000);

        // R13: read that traps returns zero
        @(negedge clk);
        el2_acc_trap = 1;
        req_valid = 1; req_write = 0; req_alias = 0; req_el = 2'd1;
        #1;
        check("R13", "trapped read data", rd_data, 64'h0);
        // R13: read that reaches the register returns its value
        el2_acc_trap = 0;
        #1;
        check("R13", "read data", rd_data, 64'h0000_0000_1020_0000);
        @(negedge clk);
        req_valid = 0;

        // R11: reset clears stored value
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        read_reg("R11", 64'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule